// File: doc/BRIEF.md
# Multicycle Phase Tracker

This block sits beside the single-cycle phase detector of a digital PLL. It counts the net slip between reference and feedback edge strobes across many clock periods. A reference edge with no matching feedback edge adds one whole unit interval (UI). A feedback edge with no matching reference edge removes one. A clock-cycle residue counter tells how long the present offset has stood. Because the count spans many cycles, the loop tolerates input jitter far larger than one period.

One limit input sets both the tracking range and the coarse lock threshold. The count saturates at that limit. An attempted slip past it raises a coarse-limit flag that a lock monitor can use as a whole-cycle-slip loss-of-lock alarm. The tracker runs whenever it is enabled, whether or not its error feeds the loop. A select input picks either the multicycle error or the external single-cycle error as the loop error. The tracker is forced off when the reference runs at a low rate, that is, when the loop locks directly at a low rate or in a low-rate lock mode.

Control is a six-state machine:
- OFF: disabled or forced off.
- LEVEL: count is zero.
- LEAD: count is positive.
- LAG: count is negative.
- OVER_LEAD: a slip past +limit was refused.
- OVER_LAG: a slip past -limit was refused.

Transitions:
- Any state goes to OFF when the tracker is disabled or forced off.
- Otherwise a refused slip up leads to OVER_LEAD, and a refused slip down leads to OVER_LAG.
- OVER_LEAD stays until a feedback-only edge steps the count down. OVER_LAG stays until a reference-only edge steps it up.
- In every other case, including leaving OFF, the next state follows the sign of the new count: LEVEL, LEAD or LAG.

Top module: `multicycle_phase_tracker`

## Requirements
- R1: After reset, valid_o is 0, mc_err_o is 0 and coarse_o is 0.
- R2: A clock with ref_edge_i=1 and fb_edge_i=0 adds one to the whole-UI count. The count sits in mc_err_o[19:6] as two's complement. The change is visible after that clock edge.
- R3: A clock with fb_edge_i=1 and ref_edge_i=0 subtracts one from the whole-UI count.
- R4: A clock with both strobes high, or both low, leaves the whole-UI count unchanged.
- R5: The count saturates at +L and -L and never wraps. L is lim_i, with 0 treated as 1, so the range is 1 to 8191 UI.
- R6: coarse_o goes high after a clock whose edge would move the count past +L or -L. It stays high until an edge steps the count back toward zero, or the tracker turns off.
- R7: mc_err_o[5:0] counts the clocks since the whole count last changed. It is 0 whenever the count is 0 and saturates at 63.
- R8: en_i=0 or low_rate_i=1 turns the tracker off from the next clock: valid_o=0, mc_err_o=0, coarse_o=0. Strobes are ignored while off. valid_o returns one clock after the tracker is turned on.
- R9: Counting behaves the same whatever the value of use_mc_i.
- R10: loop_err_o equals mc_err_o when use_mc_i=1 and valid_o=1. Otherwise it equals sc_err_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Tracker enable |
| low_rate_i | input | 1 | Low-rate reference indication, forces tracker off |
| use_mc_i | input | 1 | Use multicycle error as loop error |
| ref_edge_i | input | 1 | Reference edge strobe |
| fb_edge_i | input | 1 | Feedback edge strobe |
| lim_i | input | 13 | Range / coarse limit in UI (0 acts as 1) |
| sc_err_i | input | 20 | Single-cycle detector error |
| mc_err_o | output | 20 | {whole-UI count, residue clocks} |
| loop_err_o | output | 20 | Selected loop error |
| valid_o | output | 1 | Tracker active |
| coarse_o | output | 1 | Coarse limit exceeded |

## Verification
The bench uses runs of reference-only strobes and runs of feedback-only strobes. These show whether each direction moves the count by exactly one per edge. Coincident strobes separate a true difference count from a design that counts each input on its own. Slip runs at a small limit and at a zero limit show whether saturation holds, whether zero is read as one, and whether the coarse flag clears on a step back. Long idle gaps exercise the residue counter and its saturation. Strobes sent while the tracker is forced off show that they are ignored. The select input is flipped mid-run to show that tracking continues whichever error feeds the loop.

// File: rtl/mptrk_pkg.sv
package mptrk_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_LEVEL,
        ST_LEAD,
        ST_LAG,
        ST_OVER_LEAD,
        ST_OVER_LAG
    } trk_state_t;

    typedef enum logic [1:0] {
        STEP_NONE,
        STEP_UP,
        STEP_DN
    } step_t;
endpackage

// File: rtl/mptrk_edge_step.sv
module mptrk_edge_step
    import mptrk_pkg::*;
(
    input  logic  active_i,
    input  logic  ref_i,
    input  logic  fb_i,
    output step_t step_o
);
    always_comb begin
        step_o = STEP_NONE;
        if (active_i) begin
            if (ref_i && !fb_i) begin
                step_o = STEP_UP;
            end else if (fb_i && !ref_i) begin
                step_o = STEP_DN;
            end
        end
    end
endmodule

// File: rtl/mptrk_slip_ctr.sv
module mptrk_slip_ctr
    import mptrk_pkg::*;
#(
    parameter int LIM_W = 13
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  step_t                   step_i,
    input  logic [LIM_W-1:0]        lim_i,
    output logic signed [LIM_W:0]   diff_o,
    output logic signed [LIM_W:0]   diff_nxt_o,
    output logic                    moved_o,
    output logic                    over_hi_o,
    output logic                    over_lo_o
);
    localparam int WHOLE_W = LIM_W + 1;

    logic [LIM_W-1:0]          lim_eff;
    logic signed [WHOLE_W-1:0] lim_pos;
    logic signed [WHOLE_W-1:0] lim_neg;
    logic signed [WHOLE_W-1:0] diff_q;

    assign lim_eff = (lim_i == '0) ? LIM_W'(1) : lim_i;
    assign lim_pos = $signed({1'b0, lim_eff});
    assign lim_neg = -lim_pos;

    always_comb begin
        diff_nxt_o = diff_q;
        moved_o    = 1'b0;
        over_hi_o  = 1'b0;
        over_lo_o  = 1'b0;
        if (clr_i) begin
            diff_nxt_o = '0;
        end else begin
            unique case (step_i)
                STEP_UP: begin
                    if (diff_q < lim_pos) begin
                        diff_nxt_o = diff_q + WHOLE_W'(1);
                        moved_o    = 1'b1;
                    end else begin
                        over_hi_o  = 1'b1;
                    end
                end
                STEP_DN: begin
                    if (diff_q > lim_neg) begin
                        diff_nxt_o = diff_q - WHOLE_W'(1);
                        moved_o    = 1'b1;
                    end else begin
                        over_lo_o  = 1'b1;
                    end
                end
                default: begin
                    diff_nxt_o = diff_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            diff_q <= '0;
        end else begin
            diff_q <= diff_nxt_o;
        end
    end

    assign diff_o = diff_q;
endmodule

// File: rtl/mptrk_residue.sv
module mptrk_residue #(
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              moved_i,
    input  logic              nxt_zero_i,
    output logic [FRAC_W-1:0] frac_o
);
    localparam logic [FRAC_W-1:0] FRAC_MAX = '1;

    logic [FRAC_W-1:0] frac_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frac_q <= '0;
        end else if (clr_i || moved_i || nxt_zero_i) begin
            frac_q <= '0;
        end else if (frac_q != FRAC_MAX) begin
            frac_q <= frac_q + FRAC_W'(1);
        end
    end

    assign frac_o = frac_q;
endmodule

// File: rtl/mptrk_fsm.sv
module mptrk_fsm
    import mptrk_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  off_req_i,
    input  step_t step_i,
    input  logic  over_hi_i,
    input  logic  over_lo_i,
    input  logic  nxt_pos_i,
    input  logic  nxt_neg_i,
    output logic  valid_o,
    output logic  coarse_o
);
    trk_state_t state_q;
    trk_state_t state_nxt;
    trk_state_t sign_state;

    always_comb begin
        if (nxt_pos_i) begin
            sign_state = ST_LEAD;
        end else if (nxt_neg_i) begin
            sign_state = ST_LAG;
        end else begin
            sign_state = ST_LEVEL;
        end
    end

    always_comb begin
        state_nxt = sign_state;
        if (off_req_i) begin
            state_nxt = ST_OFF;
        end else if (over_hi_i) begin
            state_nxt = ST_OVER_LEAD;
        end else if (over_lo_i) begin
            state_nxt = ST_OVER_LAG;
        end else begin
            unique case (state_q)
                ST_OVER_LEAD: state_nxt = (step_i == STEP_DN) ? sign_state : ST_OVER_LEAD;
                ST_OVER_LAG:  state_nxt = (step_i == STEP_UP) ? sign_state : ST_OVER_LAG;
                default:      state_nxt = sign_state;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_nxt;
        end
    end

    always_comb begin
        valid_o  = 1'b1;
        coarse_o = 1'b0;
        unique case (state_q)
            ST_OFF: valid_o = 1'b0;
            ST_OVER_LEAD, ST_OVER_LAG: coarse_o = 1'b1;
            default: begin
                valid_o  = 1'b1;
                coarse_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/multicycle_phase_tracker.sv
module multicycle_phase_tracker
    import mptrk_pkg::*;
#(
    parameter int LIM_W  = 13,
    parameter int FRAC_W = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en_i,
    input  logic                      low_rate_i,
    input  logic                      use_mc_i,
    input  logic                      ref_edge_i,
    input  logic                      fb_edge_i,
    input  logic [LIM_W-1:0]          lim_i,
    input  logic [LIM_W+FRAC_W:0]     sc_err_i,
    output logic [LIM_W+FRAC_W:0]     mc_err_o,
    output logic [LIM_W+FRAC_W:0]     loop_err_o,
    output logic                      valid_o,
    output logic                      coarse_o
);
    localparam int WHOLE_W = LIM_W + 1;

    logic                      off_req;
    step_t                     step;
    logic signed [WHOLE_W-1:0] diff;
    logic signed [WHOLE_W-1:0] diff_nxt;
    logic                      moved;
    logic                      over_hi;
    logic                      over_lo;
    logic [FRAC_W-1:0]         frac;

    assign off_req = !en_i || low_rate_i;

    mptrk_edge_step u_step (
        .active_i (!off_req),
        .ref_i    (ref_edge_i),
        .fb_i     (fb_edge_i),
        .step_o   (step)
    );

    mptrk_slip_ctr #(.LIM_W(LIM_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (off_req),
        .step_i     (step),
        .lim_i      (lim_i),
        .diff_o     (diff),
        .diff_nxt_o (diff_nxt),
        .moved_o    (moved),
        .over_hi_o  (over_hi),
        .over_lo_o  (over_lo)
    );

    mptrk_residue #(.FRAC_W(FRAC_W)) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (off_req),
        .moved_i    (moved),
        .nxt_zero_i (diff_nxt == '0),
        .frac_o     (frac)
    );

    mptrk_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .off_req_i (off_req),
        .step_i    (step),
        .over_hi_i (over_hi),
        .over_lo_i (over_lo),
        .nxt_pos_i (diff_nxt > 0),
        .nxt_neg_i (diff_nxt < 0),
        .valid_o   (valid_o),
        .coarse_o  (coarse_o)
    );

    assign mc_err_o   = {diff, frac};
    assign loop_err_o = (use_mc_i && valid_o) ? mc_err_o : sc_err_i;
endmodule

// File: rtl/multicycle_phase_tracker_chk.sv
module multicycle_phase_tracker_chk #(
    parameter int LIM_W  = 13,
    parameter int FRAC_W = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  en_i,
    input logic                  low_rate_i,
    input logic                  use_mc_i,
    input logic                  ref_edge_i,
    input logic                  fb_edge_i,
    input logic [LIM_W-1:0]      lim_i,
    input logic [LIM_W+FRAC_W:0] sc_err_i,
    input logic [LIM_W+FRAC_W:0] mc_err_o,
    input logic [LIM_W+FRAC_W:0] loop_err_o,
    input logic                  valid_o,
    input logic                  coarse_o
);
    localparam int WHOLE_W = LIM_W + 1;
    localparam logic [FRAC_W-1:0] FMAX = '1;

    logic                      active;
    logic signed [WHOLE_W-1:0] whole;
    logic [FRAC_W-1:0]         frac;
    logic signed [WHOLE_W-1:0] lim_s;

    assign active = en_i && !low_rate_i;
    assign whole  = $signed(mc_err_o[LIM_W+FRAC_W:FRAC_W]);
    assign frac   = mc_err_o[FRAC_W-1:0];
    assign lim_s  = $signed({1'b0, (lim_i == '0) ? LIM_W'(1) : lim_i});

    // R8
    off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!valid_o && mc_err_o == '0 && !coarse_o));

    // R2
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && ref_edge_i && !fb_edge_i && whole < lim_s)
        |=> whole == $past(whole) + WHOLE_W'(1));

    // R3
    step_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && fb_edge_i && !ref_edge_i && whole > -lim_s)
        |=> whole == $past(whole) - WHOLE_W'(1));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && (ref_edge_i == fb_edge_i)) |=> whole == $past(whole));

    // R6
    over_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && ref_edge_i && !fb_edge_i && whole >= lim_s)
        |=> (coarse_o && whole == $past(whole)));

    // R7
    frac_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && whole != '0 && frac == FMAX && ref_edge_i == fb_edge_i)
        |=> frac == FMAX);

    // R10
    loop_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (use_mc_i && valid_o) |-> loop_err_o == mc_err_o);

    // R10
    loop_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(use_mc_i && valid_o) |-> loop_err_o == sc_err_i);
endmodule

bind multicycle_phase_tracker multicycle_phase_tracker_chk #(
    .LIM_W  (LIM_W),
    .FRAC_W (FRAC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .low_rate_i (low_rate_i),
    .use_mc_i   (use_mc_i),
    .ref_edge_i (ref_edge_i),
    .fb_edge_i  (fb_edge_i),
    .lim_i      (lim_i),
    .sc_err_i   (sc_err_i),
    .mc_err_o   (mc_err_o),
    .loop_err_o (loop_err_o),
    .valid_o    (valid_o),
    .coarse_o   (coarse_o)
);

// File: tb/multicycle_phase_tracker_tb.sv
`timescale 1ns/1ps
module multicycle_phase_tracker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0;
    logic        low_rate_i = 1'b0;
    logic        use_mc_i = 1'b0;
    logic        ref_edge_i = 1'b0;
    logic        fb_edge_i = 1'b0;
    logic [12:0] lim_i = 13'd100;
    logic [19:0] sc_err_i = 20'h0ABCD;
    logic [19:0] mc_err_o;
    logic [19:0] loop_err_o;
    logic        valid_o;
    logic        coarse_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    multicycle_phase_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .low_rate_i(low_rate_i),
        .use_mc_i(use_mc_i), .ref_edge_i(ref_edge_i), .fb_edge_i(fb_edge_i),
        .lim_i(lim_i), .sc_err_i(sc_err_i), .mc_err_o(mc_err_o),
        .loop_err_o(loop_err_o), .valid_o(valid_o), .coarse_o(coarse_o)
    );

    function automatic int whole_now();
        return int'($signed(mc_err_o[19:6]));
    endfunction

    task automatic chk_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // all tasks are entered and left at a falling edge
    task automatic pulse(input logic r, input logic f);
        ref_edge_i = r;
        fb_edge_i  = f;
        @(negedge clk);
        ref_edge_i = 1'b0;
        fb_edge_i  = 1'b0;
    endtask

    task automatic restart(input logic [12:0] lim);
        en_i = 1'b0;
        pulse(0, 0);
        lim_i = lim;
        en_i  = 1'b1;
        pulse(0, 0);
    endtask

    task automatic t_reset();
        chk_int("R1 valid", int'(valid_o), 0);
        chk_int("R1 mc_err", int'(mc_err_o), 0);
        chk_int("R1 coarse", int'(coarse_o), 0);
    endtask

    task automatic t_lead_lag();
        restart(13'd100);
        chk_int("R8 valid after enable", int'(valid_o), 1);
        for (int i = 0; i < 3; i++) pulse(1, 0);
        chk_int("R2 three ref slips", whole_now(), 3);
        chk_int("R7 residue after change", int'(mc_err_o[5:0]), 0);
        for (int i = 0; i < 5; i++) pulse(0, 0);
        chk_int("R7 residue five idle", int'(mc_err_o[5:0]), 5);
        for (int i = 0; i < 5; i++) pulse(0, 1);
        chk_int("R3 five fb slips", whole_now(), -2);
        pulse(1, 1);
        pulse(1, 1);
        chk_int("R4 coincident edges", whole_now(), -2);
        chk_int("R4 residue keeps counting", int'(mc_err_o[5:0]), 2);
        pulse(1, 0);
        pulse(1, 0);
        chk_int("R2 back to zero", whole_now(), 0);
        pulse(0, 0);
        chk_int("R7 residue zero at zero", int'(mc_err_o[5:0]), 0);
    endtask

    task automatic t_saturate();
        restart(13'd2);
        pulse(1, 0);
        pulse(1, 0);
        chk_int("R5 at limit", whole_now(), 2);
        chk_int("R6 no flag at limit", int'(coarse_o), 0);
        pulse(1, 0);
        chk_int("R5 saturated", whole_now(), 2);
        chk_int("R6 flag on overflow", int'(coarse_o), 1);
        pulse(0, 0);
        chk_int("R6 flag held", int'(coarse_o), 1);
        pulse(0, 1);
        chk_int("R6 step back value", whole_now(), 1);
        chk_int("R6 flag cleared", int'(coarse_o), 0);
        restart(13'd0);
        pulse(0, 1);
        pulse(0, 1);
        chk_int("R5 zero limit acts as one", whole_now(), -1);
        chk_int("R6 low flag", int'(coarse_o), 1);
        en_i = 1'b0;
        pulse(0, 0);
        chk_int("R6 flag cleared when off", int'(coarse_o), 0);
        restart(13'd8191);
        for (int i = 0; i < 20; i++) pulse(1, 0);
        chk_int("R5 wide range", whole_now(), 20);
        chk_int("R6 no flag wide", int'(coarse_o), 0);
    endtask

    task automatic t_forced_off();
        restart(13'd50);
        pulse(1, 0);
        low_rate_i = 1'b1;
        pulse(1, 0);
        chk_int("R8 low rate valid", int'(valid_o), 0);
        chk_int("R8 low rate mc_err", int'(mc_err_o), 0);
        pulse(1, 0);
        pulse(0, 1);
        low_rate_i = 1'b0;
        pulse(0, 0);
        chk_int("R8 valid returns", int'(valid_o), 1);
        chk_int("R8 edges ignored while off", whole_now(), 0);
    endtask

    task automatic t_residue_sat();
        restart(13'd50);
        pulse(0, 1);
        for (int i = 0; i < 70; i++) pulse(0, 0);
        chk_int("R7 residue saturates", int'(mc_err_o[5:0]), 63);
        chk_int("R7 whole kept", whole_now(), -1);
    endtask

    task automatic t_select();
        restart(13'd50);
        use_mc_i = 1'b0;
        pulse(1, 0);
        pulse(1, 0);
        chk_int("R9 tracks while unselected", whole_now(), 2);
        chk_int("R10 bypass", int'(loop_err_o), int'(sc_err_i));
        use_mc_i = 1'b1;
        pulse(1, 0);
        chk_int("R9 tracks while selected", whole_now(), 3);
        chk_int("R10 selected", int'(loop_err_o), int'(mc_err_o));
        chk_int("R10 selected value", int'(loop_err_o), 3 * 64);
        en_i = 1'b0;
        pulse(0, 0);
        chk_int("R10 off gives bypass", int'(loop_err_o), int'(sc_err_i));
        use_mc_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lead_lag();
        t_saturate();
        t_forced_off();
        t_residue_sat();
        t_select();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule